// File: doc/BRIEF.md
# Status Register and Write-Protection Controller

This block holds the protection state of a serial memory device and rules on every write. It keeps the write-enable latch and three retained protection bits: a hardware-lock enable and a two-bit protected-region code. A self-timed write-cycle counter drives the busy flag. The surrounding serial front end decodes the commands. For each command it gives this block a one-cycle strobe. At the end of each transaction it gives a commit strobe, which fires when the chip select rises. The storage array sits outside the block and takes its write go-ahead from the array allow flag.

The region code selects the protected part of the array, always counted from the top address: none, the top quarter, the top half or the whole array. The hardware lock guards only the status register. It is active when the lock enable is set and the write-protect pin is low. A status-register write is staged when its data byte arrives. It does not start until the commit strobe, and its new bits take effect when the timed cycle completes. While a cycle is in progress the status byte reads as all ones. The latch, the strobes and any new write are ignored until the cycle ends.

Top module: `swp_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, busy is low, and both allow flags are low.
- R2: When idle, the status byte is {lock enable (bit 7), 3'b000 (bits 6..4), region code high (bit 3), region code low (bit 2), write-enable latch (bit 1), busy (bit 0)}.
- R3: A started write cycle holds busy high for exactly WR_CYCLES clock cycles, beginning the cycle after the commit strobe. During that time the status byte reads 0xFF.
- R4: The set-latch strobe sets the write-enable latch. The clear-latch strobe clears it whatever the level of the write-protect pin. When both strobes fall in the same cycle, the clear wins.
- R5: The write-enable latch is cleared when any write cycle completes, whether it wrote the array or the status register.
- R6: A status write or an array commit that arrives while the write-enable latch is clear starts no cycle and changes no status bit.
- R7: The region code decides array protection. 00 protects nothing. 01 protects addresses whose two top bits are 11. 10 protects addresses whose top bit is 1. 11 protects every address. The array allow flag is high only for an unprotected address while the latch is set and the block is idle.
- R8: While the lock enable is 1 and the pin is low, status writes are refused. Array writes to unprotected addresses are still allowed when the latch is set.
- R9: While the lock enable is 0, the pin level has no effect on status writes.
- R10: If the lock becomes active between the status data byte and its commit strobe, that write is dropped and the latch stays set. If the lock becomes active after the cycle has started, the cycle completes and the write takes effect.
- R11: Of the status data byte, only bit 7 (lock enable), bit 3 and bit 2 (region code) are kept. The new values appear once the cycle ends.
- R12: While busy, the set-latch strobe, status writes and array commits are all ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_pin_i | input | 1 | Write-protect pin level; low requests the lock |
| wren_i | input | 1 | Strobe: set the write-enable latch |
| wrdi_i | input | 1 | Strobe: clear the write-enable latch |
| wrsr_i | input | 1 | Strobe: status data byte received |
| wrsr_data_i | input | 8 | Status data byte |
| sr_commit_i | input | 1 | Strobe: transaction end for a staged status write |
| arr_commit_i | input | 1 | Strobe: array page write requested at arr_addr_i |
| arr_addr_i | input | ADDR_W | Array address being checked or committed |
| status_o | output | 8 | Status byte for the status-read command |
| busy_o | output | 1 | Write cycle in progress |
| sr_allow_o | output | 1 | A status-register write would be accepted now |
| arr_allow_o | output | 1 | An array write at arr_addr_i would be accepted now |

## Verification
The hardest case to reach is the window between a staged status write and its commit. The pin must drop only after the data byte has been staged and must rise again before the commit strobe. Only then does the abort, rather than the ordinary lock refusal, decide the outcome. The bench first programs the lock enable to 1 with the pin high. It then stages a write, pulses the pin low for one cycle, and commits. It confirms that no cycle starts and that the latch is still set. A second run drops the pin only after the cycle has started and checks that the new bits land.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_WEN  = 1;
  localparam int unsigned ST_BP0  = 2;
  localparam int unsigned ST_BP1  = 3;
  localparam int unsigned ST_LOCK = 7;

  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_lvl_e;

  localparam logic [7:0] STATUS_BUSY = 8'hFF;
endpackage

// File: rtl/swp_cycle_timer.sv
module swp_cycle_timer #(
  parameter int unsigned WR_CYCLES = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(WR_CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_busy_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
  p_done_ends_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/swp_region_decode.sv
module swp_region_decode
  import swp_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic [1:0]        lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  logic [1:0] top2;
  assign top2 = addr_i[ADDR_W-1 -: 2];

  always_comb begin
    unique case (prot_lvl_e'(lvl_i))
      PROT_NONE: prot_o = 1'b0;
      PROT_QTR:  prot_o = (top2 == 2'b11);
      PROT_HALF: prot_o = top2[1];
      default:   prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/swp_status_regs.sv
module swp_status_regs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       done_i,
  input  logic       lock_i,
  input  logic       wren_i,
  input  logic       wrdi_i,
  input  logic       wrsr_i,
  input  logic [7:0] wrsr_data_i,
  input  logic       sr_commit_i,
  input  logic       arr_start_i,
  output logic       wen_o,
  output logic       lock_en_o,
  output logic [1:0] lvl_o,
  output logic       sr_start_o
);
  logic       wen_q, lock_en_q, pend_q, sr_kind_q;
  logic [1:0] lvl_q;
  logic [2:0] new_q;
  logic       unused_bits;

  assign unused_bits = ^{wrsr_data_i[6:4], wrsr_data_i[1:0]};
  assign wen_o       = wen_q;
  assign lock_en_o   = lock_en_q;
  assign lvl_o       = lvl_q;
  assign sr_start_o  = sr_commit_i && pend_q && wen_q && !lock_i && !busy_i;

  // write-enable latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wen_q <= 1'b0;
    else if (done_i)     wen_q <= 1'b0;
    else if (!busy_i) begin
      if (wrdi_i)        wen_q <= 1'b0;
      else if (wren_i)   wen_q <= 1'b1;
    end
  end

  // staged status write, dropped if the lock shows up before commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      new_q  <= '0;
    end else if (busy_i || lock_i || sr_commit_i) begin
      pend_q <= 1'b0;
    end else if (wrsr_i && wen_q) begin
      pend_q <= 1'b1;
      new_q  <= {wrsr_data_i[7], wrsr_data_i[3:2]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_kind_q <= 1'b0;
      lock_en_q <= 1'b0;
      lvl_q     <= 2'b00;
    end else begin
      if (sr_start_o)       sr_kind_q <= 1'b1;
      else if (arr_start_i) sr_kind_q <= 1'b0;
      if (done_i && sr_kind_q) begin
        lock_en_q <= new_q[2];
        lvl_q     <= new_q[1:0];
      end
    end
  end

  p_wen_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !wen_o);
  p_wrdi_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrdi_i && !busy_i |=> !wen_o);
  p_bits_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable({lock_en_o, lvl_o}));
  p_lock_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i && !busy_i |=> !sr_start_o);
endmodule

// File: rtl/swp_status_ctrl.sv
module swp_status_ctrl
  import swp_pkg::*;
#(
  parameter int unsigned DEPTH     = 1024,
  parameter int unsigned WR_CYCLES = 1000000,
  localparam int unsigned ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_pin_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              sr_commit_i,
  input  logic              arr_commit_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  output logic [7:0]        status_o,
  output logic              busy_o,
  output logic              sr_allow_o,
  output logic              arr_allow_o
);
  logic       busy, done, wen, lock_en, lock, prot, sr_start, arr_start;
  logic [1:0] lvl;

  assign lock = lock_en && !wp_pin_i;

  swp_cycle_timer #(.WR_CYCLES(WR_CYCLES)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sr_start || arr_start),
    .busy_o  (busy),
    .done_o  (done)
  );

  swp_region_decode #(.ADDR_W(ADDR_W)) i_region (
    .lvl_i  (lvl),
    .addr_i (arr_addr_i),
    .prot_o (prot)
  );

  swp_status_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy),
    .done_i      (done),
    .lock_i      (lock),
    .wren_i      (wren_i),
    .wrdi_i      (wrdi_i),
    .wrsr_i      (wrsr_i),
    .wrsr_data_i (wrsr_data_i),
    .sr_commit_i (sr_commit_i),
    .arr_start_i (arr_start),
    .wen_o       (wen),
    .lock_en_o   (lock_en),
    .lvl_o       (lvl),
    .sr_start_o  (sr_start)
  );

  assign sr_allow_o  = wen && !busy && !lock;
  assign arr_allow_o = wen && !busy && !prot;
  assign arr_start   = arr_commit_i && arr_allow_o && !sr_start;
  assign busy_o      = busy;

  always_comb begin
    status_o          = '0;
    status_o[ST_LOCK] = lock_en;
    status_o[ST_BP1]  = lvl[1];
    status_o[ST_BP0]  = lvl[0];
    status_o[ST_WEN]  = wen;
    if (busy) status_o = STATUS_BUSY;
  end

  p_all_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3:2] == 2'b11) && !busy_o |-> !arr_allow_o);
  p_lock_sr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_LOCK] && !busy_o && !wp_pin_i |-> !sr_allow_o);
  p_no_start_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !arr_allow_o && !sr_allow_o);
endmodule

// File: tb/test_swp_status_ctrl.sv
`timescale 1ns/1ps
module test_swp_status_ctrl;
  localparam int unsigned DEPTH = 1024;
  localparam int unsigned WR    = 20;
  localparam int unsigned AW    = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wp = 1'b1, wren = 0, wrdi = 0, wrsr = 0, src = 0, arc = 0;
  logic [7:0] sdata = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0] status;
  logic busy, sr_allow, arr_allow;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  swp_status_ctrl #(.DEPTH(DEPTH), .WR_CYCLES(WR)) i_swp_status_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wp_pin_i(wp), .wren_i(wren), .wrdi_i(wrdi),
    .wrsr_i(wrsr), .wrsr_data_i(sdata), .sr_commit_i(src), .arr_commit_i(arc),
    .arr_addr_i(addr), .status_o(status), .busy_o(busy),
    .sr_allow_o(sr_allow), .arr_allow_o(arr_allow));

  // {region code, address, expected allow with latch set}
  localparam logic [12:0] VEC [11] = '{
    {2'b00, 10'h000, 1'b1}, {2'b00, 10'h3FF, 1'b1},
    {2'b01, 10'h2FF, 1'b1}, {2'b01, 10'h300, 1'b0}, {2'b01, 10'h3FF, 1'b0},
    {2'b10, 10'h1FF, 1'b1}, {2'b10, 10'h200, 1'b0}, {2'b10, 10'h300, 1'b0},
    {2'b11, 10'h000, 1'b0}, {2'b11, 10'h1FF, 1'b0},
    {2'b00, 10'h3FF, 1'b1}};

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic write_sr(input logic [7:0] d);
    pulse(wren);
    sdata = d;
    pulse(wrsr);
    pulse(src);
    wait_idle();
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] cur_lvl;
    int n;
    repeat (3) @(negedge clk);
    chk({status, busy, sr_allow, arr_allow}, 8'h00, "R1 reset");
    chk({4'b0, busy, sr_allow, arr_allow, 1'b0}, 8'h00, "R1 flags");
    rst_n = 1'b1;
    @(negedge clk);

    // R6: writes with latch clear
    sdata = 8'h8C; pulse(wrsr); pulse(src);
    chk({7'b0, busy}, 8'h00, "R6 sr no start");
    addr = 10'h010; pulse(arc);
    chk({7'b0, busy}, 8'h00, "R6 arr no start");
    chk(status, 8'h00, "R6 status");

    // R4: latch set/clear independent of pin
    wp = 1'b0;
    pulse(wren);
    chk(status, 8'h02, "R4 set");
    pulse(wrdi);
    chk(status, 8'h00, "R4 clear wp low");
    wren = 1'b1; wrdi = 1'b1; @(negedge clk); wren = 1'b0; wrdi = 1'b0;
    chk(status, 8'h00, "R4 clear wins");
    wp = 1'b1;

    // R7: region table
    cur_lvl = 2'b00;
    for (int i = 0; i < 11; i++) begin
      if (VEC[i][12:11] != cur_lvl) begin
        write_sr({4'b0, VEC[i][12:11], 2'b00});
        cur_lvl = VEC[i][12:11];
        chk(status, {4'b0, cur_lvl, 2'b00}, "R2 R7 region programmed");
      end
      pulse(wren);
      addr = VEC[i][10:1];
      #0.1;
      chk({7'b0, arr_allow}, {7'b0, VEC[i][0]}, "R7 allow");
      pulse(wrdi);
    end

    // R3 R5 R12: array cycle
    pulse(wren);
    addr = 10'h010;
    pulse(arc);
    chk(status, 8'hFF, "R3 status busy");
    wren = 1'b1; sdata = 8'h8C; wrsr = 1'b1;
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
      wren = 1'b0; wrsr = 1'b0;
    end
    chk(8'(n), 8'(WR), "R3 busy length");
    chk(status, 8'h00, "R5 R12 wen cleared");
    pulse(src);
    chk({7'b0, busy}, 8'h00, "R12 wrsr during busy dropped");

    // R11: only bits 7,3,2 kept
    write_sr(8'h73);
    chk(status, 8'h00, "R11 discarded bits");
    write_sr(8'hF4);
    chk(status, 8'h84, "R11 kept bits");

    // R8: lock active
    wp = 1'b0;
    pulse(wren);
    chk({7'b0, sr_allow}, 8'h00, "R8 sr refused");
    addr = 10'h100; #0.1;
    chk({7'b0, arr_allow}, 8'h01, "R8 unprotected array ok");
    addr = 10'h300; #0.1;
    chk({7'b0, arr_allow}, 8'h00, "R8 protected array");
    sdata = 8'h00; pulse(wrsr); pulse(src);
    chk({7'b0, busy}, 8'h00, "R8 no cycle");
    chk(status, 8'h86, "R8 status kept");

    // R10: abort between data and commit
    wp = 1'b1;
    sdata = 8'h88; pulse(wrsr);
    wp = 1'b0; @(negedge clk); wp = 1'b1;
    pulse(src);
    chk({7'b0, busy}, 8'h00, "R10 aborted");
    chk(status, 8'h86, "R10 wen still set");
    pulse(wrsr); pulse(src);
    chk({7'b0, busy}, 8'h01, "R10 started");
    wp = 1'b0;
    wait_idle();
    chk(status, 8'h88, "R10 late pin no effect");
    wp = 1'b1;

    // R9: lock enable clear, pin ignored
    write_sr(8'h00);
    chk(status, 8'h00, "R9 lock enable cleared");
    wp = 1'b0;
    pulse(wren);
    chk({7'b0, sr_allow}, 8'h01, "R9 sr allowed wp low");
    write_sr(8'h08);
    chk(status, 8'h08, "R9 write with wp low");
    wp = 1'b1;

    // R12: array commit while busy ignored
    pulse(wren); addr = 10'h000; pulse(arc);
    pulse(arc);
    wait_idle();
    @(negedge clk);
    chk({7'b0, busy}, 8'h00, "R12 second commit ignored");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule